// File: doc/BRIEF.md
# Pushbutton and Power-Fail Reset Sequencer

This block owns one active-low reset line that is shared with a pushbutton. The line is open-drain: the block can only pull it low, and a pushbutton to ground can pull it low too. The block reads the level back through its input, so it sees both its own pull and the button on the same pin. In idle the block waits for the line to fall. It then grabs the line itself for a debounce interval. After that it lets go and waits until the line rises again, which means the button is released. On the release it drives a reset pulse of fixed length.

A digital power-fail flag overrides the button sequence. While the flag is set, the line is held low. When the flag clears, the line stays low for a recovery hold, and then the block returns to idle. If the oscillator-running flag is low at the moment power returns, the recovery hold is skipped and the line is released at once.

The debounce, pulse and recovery lengths are separate parameters counted in clock ticks. The pulling of the line never alters any state outside this block.

Top module: `line_reset_seq`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `pullLow` and `busy` are 0.
- R2: In idle, a falling edge on `lineIn` is seen through a two-stage synchronizer. `pullLow` rises on the third clock edge after the line falls, and stays high for exactly DEBOUNCE_TICKS cycles.
- R3: After the debounce interval, `pullLow` is 0 and `busy` stays 1 for as long as the line stays low.
- R4: A rising edge on the synchronized line during the wait raises `pullLow` on the third edge after the line rises. It stays high for exactly PULSE_TICKS cycles, after which `busy` is 0.
- R5: If the button is released before the debounce interval ends, the released line is still seen as a rising edge after the debounce, and a full reset pulse follows.
- R6: `pullLow` is 1 on the cycle after any clock edge that samples `pwrFail` high, in every state, and stays 1 while `pwrFail` stays high.
- R7: If `oscRun` is 1 on the edge that first samples `pwrFail` low, `pullLow` stays 1 for RECOVER_TICKS more cycles. After that `pullLow` and `busy` are 0.
- R8: If `oscRun` is 0 on that edge, `pullLow` and `busy` fall on that same edge.
- R9: A power-fail aborts a pushbutton sequence in progress. Afterwards the block is idle. A button that is still held, and its later release, start no new sequence.
- R10: If `pwrFail` returns during the recovery hold, the line is forced low again. The next clear starts a full recovery hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Level read back from the shared reset line (1 = released) |
| pwrFail | input | 1 | Supply-failure flag, 1 = power bad |
| oscRun | input | 1 | 1 when the timekeeping oscillator is running |
| pullLow | output | 1 | 1 enables the open-drain pull-down on the line |
| busy | output | 1 | 1 whenever the sequencer is not idle |

## Verification
Most faults here show up as the wrong length of a low pulse, or as a pulse where none should be. Two examples are a timer loaded with the wrong interval and an edge detector that sees the block's own pull as a new press. Both change the pulse edges within a few cycles of the state entry, so every scenario compares `pullLow` and `busy` cycle by cycle against a window computed from the press, release and power-fail times. If the state machine lands in the wrong state after an abort, it shows up as a spurious pulse while the still-held button is released. The bench watches for this over a fixed quiet window after that release.

// File: rtl/line_reset_seq_pkg.sv
package line_reset_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DEBOUNCE = 3'd1,
    ST_WAIT_REL = 3'd2,
    ST_PULSE    = 3'd3,
    ST_PFAIL    = 3'd4,
    ST_RECOVER  = 3'd5
  } seqStateT;

  typedef enum logic [1:0] {
    SEL_DEBOUNCE = 2'd0,
    SEL_PULSE    = 2'd1,
    SEL_RECOVER  = 2'd2
  } timerSelT;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    timerSelT sel;
  } dpCmdT;

  // observations from datapath to control
  typedef struct packed {
    logic fallEdge;
    logic riseEdge;
    logic timerDone;
  } dpStatT;

endpackage

// File: rtl/line_reset_seq_dp.sv
module line_reset_seq_dp
  import line_reset_seq_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int DEBOUNCE_TICKS = 8192,
  parameter int PULSE_TICKS    = 8192,
  parameter int RECOVER_TICKS  = 8192,
  parameter int CNT_W          = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lineIn,
  input  dpCmdT            cmd,
  output dpStatT           stat,
  output logic [CNT_W-1:0] timerVal
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineSync;
  logic                   linePrev;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       loadVal;

  // idle level of the line is high, so the synchronizer resets to ones
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= '1;
        else        syncQ <= lineIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= '1;
        else        syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      end
    end
  endgenerate

  assign lineSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) linePrev <= 1'b1;
    else        linePrev <= lineSync;
  end

  always_comb begin
    unique case (cmd.sel)
      SEL_DEBOUNCE: loadVal = CNT_W'(DEBOUNCE_TICKS);
      SEL_PULSE:    loadVal = CNT_W'(PULSE_TICKS);
      default:      loadVal = CNT_W'(RECOVER_TICKS);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (cmd.load)      cnt <= loadVal;
    else if (cnt != '0)     cnt <= cnt - CNT_W'(1);
  end

  assign stat.fallEdge  = linePrev & ~lineSync;
  assign stat.riseEdge  = ~linePrev & lineSync;
  assign stat.timerDone = (cnt == CNT_W'(1));
  assign timerVal       = cnt;

endmodule

// File: rtl/line_reset_seq_ctrl.sv
module line_reset_seq_ctrl
  import line_reset_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pwrFail,
  input  logic     oscRun,
  input  dpStatT   stat,
  output dpCmdT    cmd,
  output seqStateT state,
  output logic     pullLow,
  output logic     busy
);

  seqStateT nextState;

  always_comb begin
    nextState = state;
    cmd.load  = 1'b0;
    cmd.sel   = SEL_DEBOUNCE;
    if (pwrFail) begin
      nextState = ST_PFAIL;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (stat.fallEdge) begin
            nextState = ST_DEBOUNCE;
            cmd.load  = 1'b1;
            cmd.sel   = SEL_DEBOUNCE;
          end
        end
        ST_DEBOUNCE: begin
          if (stat.timerDone) nextState = ST_WAIT_REL;
        end
        ST_WAIT_REL: begin
          if (stat.riseEdge) begin
            nextState = ST_PULSE;
            cmd.load  = 1'b1;
            cmd.sel   = SEL_PULSE;
          end
        end
        ST_PULSE: begin
          if (stat.timerDone) nextState = ST_IDLE;
        end
        ST_PFAIL: begin
          if (oscRun) begin
            nextState = ST_RECOVER;
            cmd.load  = 1'b1;
            cmd.sel   = SEL_RECOVER;
          end else begin
            nextState = ST_IDLE;
          end
        end
        ST_RECOVER: begin
          if (stat.timerDone) nextState = ST_IDLE;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign pullLow = (state == ST_DEBOUNCE) || (state == ST_PULSE) ||
                   (state == ST_PFAIL)    || (state == ST_RECOVER);
  assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/line_reset_seq.sv
module line_reset_seq
  import line_reset_seq_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int DEBOUNCE_TICKS = 8192,
  parameter int PULSE_TICKS    = 8192,
  parameter int RECOVER_TICKS  = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lineIn,
  input  logic pwrFail,
  input  logic oscRun,
  output logic pullLow,
  output logic busy
);

  localparam int MAX_DP = (DEBOUNCE_TICKS > PULSE_TICKS) ? DEBOUNCE_TICKS : PULSE_TICKS;
  localparam int MAX_T  = (MAX_DP > RECOVER_TICKS) ? MAX_DP : RECOVER_TICKS;
  localparam int CNT_W  = $clog2(MAX_T + 1);

  dpCmdT            cmd;
  dpStatT           stat;
  seqStateT         seqState;
  logic [CNT_W-1:0] timerVal;

  line_reset_seq_dp #(
    .SYNC_STAGES   (SYNC_STAGES),
    .DEBOUNCE_TICKS(DEBOUNCE_TICKS),
    .PULSE_TICKS   (PULSE_TICKS),
    .RECOVER_TICKS (RECOVER_TICKS),
    .CNT_W         (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .lineIn  (lineIn),
    .cmd     (cmd),
    .stat    (stat),
    .timerVal(timerVal)
  );

  line_reset_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwrFail(pwrFail),
    .oscRun (oscRun),
    .stat   (stat),
    .cmd    (cmd),
    .state  (seqState),
    .pullLow(pullLow),
    .busy   (busy)
  );

endmodule

// File: rtl/line_reset_seq_chk.sv
module line_reset_seq_chk
  import line_reset_seq_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int DB_TICKS = 8192
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwrFail,
  input logic             oscRun,
  input logic             pullLow,
  input logic             busy,
  input seqStateT         state,
  input logic [CNT_W-1:0] timer
);

  assert_debounce_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEBOUNCE) |-> (timer != '0 && timer <= CNT_W'(DB_TICKS)));

  assert_debounce_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEBOUNCE && timer == CNT_W'(1) && !pwrFail) |=> (!pullLow && busy));

  assert_pulse_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PULSE && timer == CNT_W'(1) && !pwrFail) |=> !busy);

  assert_pf_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwrFail |=> pullLow);

  assert_recover_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PFAIL && !pwrFail && oscRun) |=> (pullLow && timer != '0));

  assert_recover_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PFAIL && !pwrFail && !oscRun) |=> (!pullLow && !busy));

  assert_recover_reentry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOVER && pwrFail) |=> (state == ST_PFAIL));

endmodule

bind line_reset_seq line_reset_seq_chk #(
  .CNT_W   (CNT_W),
  .DB_TICKS(DEBOUNCE_TICKS)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pwrFail(pwrFail),
  .oscRun (oscRun),
  .pullLow(pullLow),
  .busy   (busy),
  .state  (seqState),
  .timer  (timerVal)
);

// File: tb/line_reset_seq_bench.sv
`timescale 1ns/1ps
module line_reset_seq_bench;

  localparam int DB = 4;
  localparam int PL = 5;
  localparam int RC = 6;
  localparam int NPUSH = 6;
  // {hold step of the button, expected step where the reset pulse begins}
  // pulse start = max(hold, 3 + DB) + 3
  localparam int PUSH_TAB [NPUSH][2] = '{
    '{2, 10}, '{5, 10}, '{6, 10}, '{7, 10}, '{12, 15}, '{30, 33}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btnDown = 1'b0;
  logic pwrFail = 1'b0;
  logic oscRun = 1'b1;
  logic lineIn;
  logic pullLow;
  logic busy;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  assign lineIn = ~(pullLow | btnDown);

  line_reset_seq #(
    .SYNC_STAGES   (2),
    .DEBOUNCE_TICKS(DB),
    .PULSE_TICKS   (PL),
    .RECOVER_TICKS (RC)
  ) u_line_reset_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .lineIn (lineIn),
    .pwrFail(pwrFail),
    .oscRun (oscRun),
    .pullLow(pullLow),
    .busy   (busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare pullLow/busy against expected windows; records first mismatch
  task automatic cmpStep(input int s, input bit expP, input bit expB,
                         inout int badStep, inout int actV, inout int expV);
    if (badStep < 0 && (pullLow !== expP || busy !== expB)) begin
      badStep = s;
      actV = {pullLow, busy};
      expV = {expP, expB};
    end
  endtask

  task automatic runPf(input int clr, input bit osc, input int expHi, input string req);
    int badStep = -1;
    int actV = 0;
    int expV = 0;
    oscRun = osc;
    pwrFail = 1'b1;
    for (int s = 1; s <= clr + RC + 8; s++) begin
      @(negedge clk);
      cmpStep(s, s <= expHi, s <= expHi, badStep, actV, expV);
      if (s == clr) pwrFail = 1'b0;
    end
    check(badStep < 0, req, $sformatf("pf window {pullLow,busy} step %0d", badStep), actV, expV);
  endtask

  task automatic runAbort(input int pfOn, input int pfOff, input bit osc, input int expHi);
    int badStep = -1;
    int actV = 0;
    int expV = 0;
    oscRun = osc;
    btnDown = 1'b1;
    for (int s = 1; s <= 40; s++) begin
      @(negedge clk);
      cmpStep(s, (s >= 3 && s < 3 + DB && s <= pfOn) || (s > pfOn && s <= expHi),
                 (s >= 3 && s <= pfOn) || (s > pfOn && s <= expHi),
              badStep, actV, expV);
      if (s == pfOn) pwrFail = 1'b1;
      if (s == pfOff) pwrFail = 1'b0;
    end
    check(badStep < 0, "R9", $sformatf("abort window step %0d", badStep), actV, expV);
    // releasing the still-held button must not start a new sequence
    btnDown = 1'b0;
    badStep = -1;
    for (int s = 1; s <= 12; s++) begin
      @(negedge clk);
      cmpStep(s, 1'b0, 1'b0, badStep, actV, expV);
    end
    check(badStep < 0, "R9", $sformatf("quiet after release step %0d", badStep), actV, expV);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(pullLow == 1'b0 && busy == 1'b0, "R1", "outputs in reset", {pullLow, busy}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pullLow == 1'b0 && busy == 1'b0, "R1", "outputs after reset", {pullLow, busy}, 0);

    // table: pushbutton press/release patterns (R2 R3 R4 R5)
    for (int i = 0; i < NPUSH; i++) begin
      int hold = PUSH_TAB[i][0];
      int pst = PUSH_TAB[i][1];
      int badStep = -1;
      int actV = 0;
      int expV = 0;
      btnDown = 1'b1;
      for (int s = 1; s <= 50; s++) begin
        @(negedge clk);
        cmpStep(s, (s >= 3 && s < 3 + DB) || (s >= pst && s < pst + PL),
                   (s >= 3 && s < pst + PL), badStep, actV, expV);
        if (s == hold) btnDown = 1'b0;
      end
      check(badStep < 0, hold < 3 + DB ? "R2 R5" : "R2 R3 R4",
            $sformatf("push hold=%0d step %0d", hold, badStep), actV, expV);
      repeat (4) @(negedge clk);
    end

    // R6 R7: power fail with oscillator running
    runPf(10, 1'b1, 10 + RC, "R6 R7");
    repeat (4) @(negedge clk);
    // R8: oscillator stopped, no recovery hold
    runPf(7, 1'b0, 7, "R6 R8");
    repeat (4) @(negedge clk);

    // R9: abort during wait-for-release, and during debounce
    runAbort(10, 15, 1'b0, 15);
    repeat (4) @(negedge clk);
    runAbort(4, 8, 1'b1, 8 + RC);
    repeat (4) @(negedge clk);

    // R10: power fail returns during recovery
    begin
      int badStep = -1;
      int actV = 0;
      int expV = 0;
      oscRun = 1'b1;
      pwrFail = 1'b1;
      for (int s = 1; s <= 30; s++) begin
        @(negedge clk);
        cmpStep(s, s <= 12 + RC, s <= 12 + RC, badStep, actV, expV);
        if (s == 5) pwrFail = 1'b0;
        if (s == 8) pwrFail = 1'b1;
        if (s == 12) pwrFail = 1'b0;
      end
      check(badStep < 0, "R10", $sformatf("re-entry step %0d", badStep), actV, expV);
    end

    // R1: reset in the middle of a forced hold
    pwrFail = 1'b1;
    repeat (3) @(negedge clk);
    pwrFail = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(pullLow == 1'b0 && busy == 1'b0, "R1", "reset aborts hold", {pullLow, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule